// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

The block is a combinational arithmetic/logic unit for 8-bit or 16-bit operands. It covers addition and addition with carry, subtraction and compare, and the bitwise AND, OR, XOR, NOT and test operations. An operation code selects the operation, and a width input selects byte or word. Alongside the result it produces six status flags: carry, parity, auxiliary carry, zero, sign and overflow. It also produces a write-enable that tells the surrounding datapath whether the destination register should take the result.

A small flag register is attached to the unit. When the load input is high, the flags computed in a cycle are captured at the clock edge. Otherwise the stored flags are held. The stored carry feeds the add-with-carry operation. The stored flags also pass through unchanged on operations that must not disturb the flags.

Top module: `flag_alu16`

## Requirements
- R1: ADD (op 0) gives a+b and ADC (op 1) gives a+b+the stored carry (flags_q_o bit 0), both truncated to the selected width. CF (flags bit 0) is the carry out of the top bit of that width.
- R2: SUB (op 2) and CMP (op 3) compute a-b, and CF is set when b is greater than a (unsigned borrow). For CMP, equal operands give ZF=1 and CF=0, a greater a gives ZF=0 and CF=0, and a smaller a gives CF=1.
- R3: AF (flags bit 2) is the carry out of bit 3 on add, or the borrow into bit 3 on subtract. Logical operations clear AF.
- R4: PF (flags bit 1) is 1 when bits 7:0 of the result hold an even number of ones, in either width.
- R5: ZF (flags bit 3) is 1 when the result within the selected width is zero. SF (flags bit 4) equals the top bit of the result within that width.
- R6: OF (flags bit 5) flags a signed overflow. On add it is set when both operands share a sign that the result lacks. On subtract it is set when the operands differ in sign and the result sign differs from a.
- R7: AND (op 4), OR (op 5), XOR (op 6) and TEST (op 8) give the bitwise result and clear CF and OF.
- R8: NOT (op 7) gives ~a within the width, and flags_o equals the stored flags, so no flag changes.
- R9: wr_o is 0 for CMP and TEST and 1 for ops 0 to 2 and 4 to 7. The result output still shows the difference or the AND value.
- R10: With wide_i=0 (byte), bits 15:8 of the inputs have no effect and bits 15:8 of the result are zero.
- R11: Reset clears the stored flags. A cycle with load_i=1 stores flags_o at the clock edge, and a cycle with load_i=0 keeps the stored flags.
- R12: Op codes 9 to 15 give result 0, wr_o=0, and flags_o equal to the stored flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = word, 0 = byte |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| load_i | input | 1 | Store flags_o at the next edge |
| res_o | output | 16 | Result |
| wr_o | output | 1 | Destination write-enable |
| flags_o | output | 6 | Flags of this operation {OF,SF,ZF,AF,PF,CF} |
| flags_q_o | output | 6 | Stored flags, same bit order |

## Verification
Additions that wrap the full word are set against additions that stay in range, which separates the carry and zero flags from a plain sum. Byte-mode additions carry junk in the upper input bits and cross the signed boundary, which separates byte-width overflow and sign from word-width behaviour. The three compare orderings (equal, larger, smaller), and subtractions that cross the sign boundary, distinguish borrow from signed overflow. NOT, TEST and the undefined op codes, each issued after a flag load, show whether the stored flags pass through untouched and whether the write-enable is withheld.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_TEST = 4'd8
    } alu_op_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } flags_t;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOT = 2'd3
    } logic_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    input  logic         cin_i,
    input  logic         wide_i,
    output logic [W-1:0] res_o,
    output logic         cf_o,
    output logic         af_o,
    output logic         of_o
);
    localparam int H = W / 2;

    logic [W-1:0] bb;
    logic         c0;
    logic [H:0]   lo_sum;
    logic [H:0]   hi_sum;
    logic [4:0]   nib_sum;
    logic         sa, sb, sr, carry;

    always_comb begin
        bb      = sub_i ? ~b_i : b_i;
        c0      = sub_i ? 1'b1 : cin_i;
        lo_sum  = {1'b0, a_i[H-1:0]} + {1'b0, bb[H-1:0]} + {{H{1'b0}}, c0};
        hi_sum  = {1'b0, a_i[W-1:H]} + {1'b0, bb[W-1:H]} + {{H{1'b0}}, lo_sum[H]};
        nib_sum = {1'b0, a_i[3:0]} + {1'b0, bb[3:0]} + {4'd0, c0};
        if (wide_i) begin
            res_o = {hi_sum[H-1:0], lo_sum[H-1:0]};
            carry = hi_sum[H];
            sa    = a_i[W-1];
            sb    = bb[W-1];
            sr    = hi_sum[H-1];
        end else begin
            res_o = {{(W-H){1'b0}}, lo_sum[H-1:0]};
            carry = lo_sum[H];
            sa    = a_i[H-1];
            sb    = bb[H-1];
            sr    = lo_sum[H-1];
        end
        cf_o = carry ^ sub_i;
        af_o = nib_sum[4] ^ sub_i;
        of_o = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_sel_e   sel_i,
    input  logic         wide_i,
    output logic [W-1:0] res_o
);
    localparam int H = W / 2;

    logic [W-1:0] raw;

    always_comb begin
        unique case (sel_i)
            LG_AND:  raw = a_i & b_i;
            LG_OR:   raw = a_i | b_i;
            LG_XOR:  raw = a_i ^ b_i;
            default: raw = ~a_i;
        endcase
        res_o = wide_i ? raw : {{(W-H){1'b0}}, raw[H-1:0]};
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t flags_i,
    output flags_t flags_o
);
    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.flags = flags_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;

    assert_latch_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> flags_o == $past(flags_i));
    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_o));
endmodule

// File: rtl/flag_alu16.sv
module flag_alu16
    import alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op_i,
    input  logic         wide_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         load_i,
    output logic [W-1:0] res_o,
    output logic         wr_o,
    output logic [5:0]   flags_o,
    output logic [5:0]   flags_q_o
);
    localparam int H = W / 2;

    logic [W-1:0] as_res, lg_res;
    logic         as_cf, as_af, as_of;
    logic         is_sub;
    logic_sel_e   lg_sel;
    flags_t       fl_d, fl_q;
    logic         zf, sf, pf;

    assign is_sub = (op_i == OP_SUB) || (op_i == OP_CMP);

    alu_addsub #(.W(W)) u_addsub (
        .a_i    (a_i),
        .b_i    (b_i),
        .sub_i  (is_sub),
        .cin_i  ((op_i == OP_ADC) ? fl_q.cf : 1'b0),
        .wide_i (wide_i),
        .res_o  (as_res),
        .cf_o   (as_cf),
        .af_o   (as_af),
        .of_o   (as_of)
    );

    always_comb begin
        case (op_i)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            OP_NOT:  lg_sel = LG_NOT;
            default: lg_sel = LG_AND;
        endcase
    end

    alu_logic #(.W(W)) u_logic (
        .a_i    (a_i),
        .b_i    (b_i),
        .sel_i  (lg_sel),
        .wide_i (wide_i),
        .res_o  (lg_res)
    );

    always_comb begin
        res_o = '0;
        wr_o  = 1'b0;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB: begin res_o = as_res; wr_o = 1'b1; end
            OP_CMP:                 begin res_o = as_res; wr_o = 1'b0; end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin res_o = lg_res; wr_o = 1'b1; end
            OP_TEST:                begin res_o = lg_res; wr_o = 1'b0; end
            default:                begin res_o = '0; wr_o = 1'b0; end
        endcase
        zf = wide_i ? (res_o == '0) : (res_o[H-1:0] == '0);
        sf = wide_i ? res_o[W-1] : res_o[H-1];
        pf = ~^res_o[7:0];
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_CMP:
                fl_d = '{of: as_of, sf: sf, zf: zf, af: as_af, pf: pf, cf: as_cf};
            OP_AND, OP_OR, OP_XOR, OP_TEST:
                fl_d = '{of: 1'b0, sf: sf, zf: zf, af: 1'b0, pf: pf, cf: 1'b0};
            default:
                fl_d = fl_q;
        endcase
    end

    alu_flag_reg u_freg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .flags_i (fl_d),
        .flags_o (fl_q)
    );

    assign flags_o   = fl_d;
    assign flags_q_o = fl_q;

    assert_byte_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> res_o[W-1:H] == '0);
    assert_logic_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_TEST)
        |-> (!flags_o[0] && !flags_o[5]));
    assert_cmp_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CMP && wide_i && a_i == b_i) |-> (flags_o[3] && !flags_o[0] && !wr_o));
    assert_not_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_NOT) |-> flags_o == flags_q_o);
    assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8) |-> (res_o == '0 && !wr_o && flags_o == flags_q_o));
endmodule

// File: tb/sim_flag_alu16.sv
module sim_flag_alu16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = 4'd7;
    logic        wide_i = 1'b1;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        load_i = 1'b0;
    logic [15:0] res_o;
    logic        wr_o;
    logic [5:0]  flags_o, flags_q_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct packed {
        logic [15:0] res;
        logic        wr;
        logic [5:0]  fl;
        logic [5:0]  fq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    logic [5:0] model_fq = '0;

    always #4 clk = ~clk;

    flag_alu16 u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i),
        .a_i(a_i), .b_i(b_i), .load_i(load_i),
        .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o), .flags_q_o(flags_q_o)
    );

    task automatic apply(input logic [3:0] op, input logic w, input logic [15:0] a,
                         input logic [15:0] b, input logic ld, input string tag);
        logic [15:0] mask, ua, ub, r;
        logic [16:0] full;
        logic cf, af, of, wr, keep, lgc, sa, sb, sr;
        int n;
        exp_t e;
        n    = w ? 16 : 8;
        mask = w ? 16'hFFFF : 16'h00FF;
        ua = a & mask;
        ub = b & mask;
        cf = 0; af = 0; of = 0; wr = 0; keep = 0; lgc = 0; r = '0;
        case (op)
            4'd0, 4'd1: begin
                full = {1'b0, ua} + {1'b0, ub} + {16'd0, (op == 4'd1) ? model_fq[0] : 1'b0};
                r  = full[15:0] & mask;
                cf = w ? full[16] : full[8];
                af = ({1'b0, ua[3:0]} + {1'b0, ub[3:0]} + {4'd0, (op == 4'd1) ? model_fq[0] : 1'b0}) > 5'd15;
                sa = ua[n-1]; sb = ub[n-1]; sr = r[n-1];
                of = (sa == sb) && (sr != sa);
                wr = 1;
            end
            4'd2, 4'd3: begin
                r  = (ua - ub) & mask;
                cf = ua < ub;
                af = ua[3:0] < ub[3:0];
                sa = ua[n-1]; sb = ub[n-1]; sr = r[n-1];
                of = (sa != sb) && (sr != sa);
                wr = (op == 4'd2);
            end
            4'd4: begin r = ua & ub; wr = 1; lgc = 1; end
            4'd5: begin r = ua | ub; wr = 1; lgc = 1; end
            4'd6: begin r = ua ^ ub; wr = 1; lgc = 1; end
            4'd7: begin r = ~ua & mask; wr = 1; keep = 1; end
            4'd8: begin r = ua & ub; wr = 0; lgc = 1; end
            default: begin r = '0; wr = 0; keep = 1; end
        endcase
        e.res = r;
        e.wr  = wr;
        e.fq  = model_fq;
        if (keep) e.fl = model_fq;
        else      e.fl = {of, r[n-1], (r == 16'd0), af, ~^r[7:0], cf};
        @(negedge clk);
        op_i = op; wide_i = w; a_i = a; b_i = b; load_i = ld;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (ld) model_fq = e.fl;
    endtask

    initial begin : monitor
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (res_o !== e.res || wr_o !== e.wr || flags_o !== e.fl || flags_q_o !== e.fq) begin
                    n_bad++;
                    $display("FAIL %s: res=%h wr=%b fl=%b fq=%b expected res=%h wr=%b fl=%b fq=%b",
                             t, res_o, wr_o, flags_o, flags_q_o, e.res, e.wr, e.fl, e.fq);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(4'd7, 1, 16'h1234, 16'h0000, 0, "R11 reset state / R8 not");
        apply(4'd0, 1, 16'hFFFF, 16'h0001, 1, "R1 word add wrap");
        apply(4'd7, 1, 16'h0000, 16'h5555, 0, "R8 not keeps flags");
        apply(4'd1, 1, 16'h0010, 16'h0020, 1, "R1 adc with carry set");
        apply(4'd1, 1, 16'h0001, 16'h0001, 0, "R1 adc carry clear");
        apply(4'd0, 0, 16'h127F, 16'hAB01, 1, "R6 R10 byte add overflow");
        apply(4'd0, 0, 16'hFF08, 16'h0008, 0, "R3 nibble carry");
        apply(4'd2, 1, 16'h8000, 16'h0001, 1, "R6 sub overflow");
        apply(4'd3, 1, 16'h1234, 16'h1234, 0, "R2 cmp equal");
        apply(4'd3, 1, 16'h5000, 16'h1234, 0, "R2 cmp greater");
        apply(4'd3, 1, 16'h0001, 16'h8000, 0, "R2 cmp less");
        apply(4'd2, 0, 16'hAA05, 16'h5506, 1, "R2 R10 byte borrow");
        apply(4'd4, 1, 16'hF0F0, 16'h0FFF, 0, "R7 and");
        apply(4'd5, 1, 16'h8001, 16'h0100, 0, "R5 R7 or sign");
        apply(4'd0, 1, 16'hC000, 16'hC000, 1, "R1 set carry before xor");
        apply(4'd6, 1, 16'hAAAA, 16'hAAAA, 1, "R5 R7 xor zero clears cf");
        apply(4'd8, 1, 16'hFF00, 16'h0F00, 0, "R9 test no write");
        apply(4'd0, 1, 16'h0300, 16'h0000, 0, "R4 parity low byte even");
        apply(4'd0, 1, 16'h0100, 16'h0001, 0, "R4 parity low byte odd");
        apply(4'd0, 1, 16'hFFFF, 16'h0001, 1, "R11 load flags");
        apply(4'd9, 1, 16'h1234, 16'h4321, 0, "R12 undefined op 9");
        apply(4'd15, 0, 16'hFFFF, 16'hFFFF, 0, "R12 undefined op 15");
        apply(4'd0, 1, 16'h0001, 16'h0001, 0, "R11 compute without load");
        apply(4'd7, 0, 16'hFF12, 16'h0000, 0, "R11 R10 R8 hold and byte not");
        repeat (4) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule